// File: doc/BRIEF.md
# Single-Wire Bus Master Engine

This block is the master of one open-drain single-wire bus. It pulls the line low by asserting a drive-low enable and releases it by dropping that enable. A pull-up outside the block raises the line. All bus timing is counted in ticks of `TICK_DIV` system clocks. With the default value and a 100 MHz clock, one tick lasts 6 us. The tick divider restarts whenever a new reset or slot begins, so every phase lasts an exact whole number of ticks.

A host issues commands over a valid/ready interface. A bus reset returns a presence flag. The flag is decided by sampling the released line 32 times across a fixed window. A byte write sends bits LSB first, one bit per slot. It returns the byte sampled back during those slots. A byte read is a write of all ones, with the device pulling the line low on its zero bits. Three single-slot commands let a higher-level sequencer run individual bits. Each command produces exactly one response pulse. The block holds `busy_o` from the moment it accepts a command until that response appears.

Top module: `ow_master`

## Requirements
- R1: One tick equals `TICK_DIV` clock cycles. The tick count restarts when a reset or slot begins, so a low phase of N ticks drives `bus_drive_low_o` for exactly N×`TICK_DIV` cycles.
- R2: A reset command releases the bus for 10 ticks and then drives it low for 80 ticks.
- R3: After the reset low phase, the line is sampled 32 times, 2 ticks apart. The first sample is taken 5 ticks after release. `rsp_presence_o` is 1 if and only if at least one sample is low, so a pulse that ends before the first sample does not count.
- R4: The reset response arrives 80 ticks after the bus is released, within 2 cycles.
- R5: Every slot starts with 2 ticks of released bus and then drives the bus low. A one-slot is low for 1 tick; a zero-slot is low for 10 ticks. Inside a multi-bit command, consecutive low edges are 12 ticks apart, within 2 cycles.
- R6: A one-slot samples the synchronised line 2 ticks after its low edge and stores that value as the slot's result bit.
- R7: A zero-slot always yields a result bit of 0.
- R8: Command code 1 (write byte) sends `cmd_data_i` LSB first in 8 slots. Response bit i is the result of slot i.
- R9: Command code 2 (read byte) runs 8 one-slots. It returns the sampled bits, LSB first.
- R10: Codes 3, 4 and 5 run one zero-slot, one one-slot and one read slot. Codes 6 and 7 act as code 5. The result is in `rsp_data_o` bit 0, and the other bits are 0. Code 0 is reset.
- R11: `cmd_ready_o` is the inverse of `busy_o`. After reset, `busy_o` is 0 and the bus is released. A command offered while busy is ignored. The response raises `rsp_valid_o` for one cycle with `busy_o` already 0, and the bus is never driven while not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command will be taken on this cycle |
| cmd_op_i | input | 3 | Command code (see R10) |
| cmd_data_i | input | DATA_W | Byte to write |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_data_o | output | DATA_W | Sampled byte or bit |
| rsp_presence_o | output | 1 | Device presence seen by the last reset |
| busy_o | output | 1 | Command in progress |
| bus_i | input | 1 | Raw bus line level |
| bus_drive_low_o | output | 1 | Enable of the open-drain low driver |

## Verification
A wrong phase counter or a wrong tick restart shows up at once on `bus_drive_low_o`: the low pulse of a reset or slot becomes longer or shorter by whole ticks, and the edge-to-edge slot spacing drifts. A broken sample point or presence window shows up only in the response, one reset or byte later. The bench therefore places device pulses just before the first presence sample and just before the last one. A fault in the command sequencer shows up as a wrong slot count, a stray slot after the response, or `rsp_valid_o` arriving while `busy_o` is still high.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_WR_BYTE = 3'd1,
    OP_RD_BYTE = 3'd2,
    OP_WR0     = 3'd3,
    OP_WR1     = 3'd4,
    OP_RD_BIT  = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_IDLE, S_RST_LOW, S_PR_WAIT, S_PR_SAMP, S_PR_TAIL,
    S_REC, S_LOW, S_W1_WAIT, S_W1_REST, S_W0_LOW
  } slot_st_e;

  // phase lengths in ticks
  localparam int T_RST_IDLE = 10;
  localparam int T_RST_LOW  = 80;
  localparam int T_PR_WAIT  = 4;
  localparam int T_PR_SAMP  = 64;
  localparam int T_PR_TAIL  = 12;
  localparam int T_REC      = 2;
  localparam int T_LOW      = 1;
  localparam int T_W1_WAIT  = 1;
  localparam int T_W1_REST  = 8;
  localparam int T_W0_LOW   = 9;
  localparam int CNT_W      = $clog2(T_RST_LOW);
endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
  parameter int DIV = 600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (cnt_q == W'(DIV - 1))   cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == W'(DIV - 1));

  generate
    if (DIV > 1) begin : g_gap
      assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
  import ow_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_rst_i,
  input  logic start_bit_i,
  input  logic bit_val_i,
  input  logic bus_i,
  output logic drive_low_o,
  output logic done_o,
  output logic rx_bit_o,
  output logic presence_o
);
  slot_st_e st_q, st_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic wr1_q;

  function automatic logic [CNT_W-1:0] len_of(slot_st_e s);
    case (s)
      S_RST_IDLE: len_of = CNT_W'(T_RST_IDLE - 1);
      S_RST_LOW:  len_of = CNT_W'(T_RST_LOW - 1);
      S_PR_WAIT:  len_of = CNT_W'(T_PR_WAIT - 1);
      S_PR_SAMP:  len_of = CNT_W'(T_PR_SAMP - 1);
      S_PR_TAIL:  len_of = CNT_W'(T_PR_TAIL - 1);
      S_REC:      len_of = CNT_W'(T_REC - 1);
      S_LOW:      len_of = CNT_W'(T_LOW - 1);
      S_W1_WAIT:  len_of = CNT_W'(T_W1_WAIT - 1);
      S_W1_REST:  len_of = CNT_W'(T_W1_REST - 1);
      S_W0_LOW:   len_of = CNT_W'(T_W0_LOW - 1);
      default:    len_of = '0;
    endcase
  endfunction

  always_comb begin
    case (st_q)
      S_RST_IDLE: st_nxt = S_RST_LOW;
      S_RST_LOW:  st_nxt = S_PR_WAIT;
      S_PR_WAIT:  st_nxt = S_PR_SAMP;
      S_PR_SAMP:  st_nxt = S_PR_TAIL;
      S_REC:      st_nxt = S_LOW;
      S_LOW:      st_nxt = wr1_q ? S_W1_WAIT : S_W0_LOW;
      S_W1_WAIT:  st_nxt = S_W1_REST;
      default:    st_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      cnt_q      <= '0;
      wr1_q      <= 1'b0;
      done_o     <= 1'b0;
      rx_bit_o   <= 1'b0;
      presence_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (st_q == S_IDLE) begin
        if (start_rst_i) begin
          st_q       <= S_RST_IDLE;
          cnt_q      <= len_of(S_RST_IDLE);
          presence_o <= 1'b0;
        end else if (start_bit_i) begin
          st_q     <= S_REC;
          cnt_q    <= len_of(S_REC);
          wr1_q    <= bit_val_i;
          rx_bit_o <= 1'b0;
        end
      end else if (tick_i) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
          // odd counts give 32 samples, 2 ticks apart
          if (st_q == S_PR_SAMP && cnt_q[0] && !bus_i) presence_o <= 1'b1;
        end else begin
          st_q  <= st_nxt;
          cnt_q <= len_of(st_nxt);
          if (st_q == S_W1_WAIT) rx_bit_o <= bus_i;
          if (st_nxt == S_IDLE)  done_o   <= 1'b1;
        end
      end
    end
  end

  assign drive_low_o = (st_q == S_RST_LOW) || (st_q == S_LOW) || (st_q == S_W0_LOW);

  assert_start_when_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_rst_i || start_bit_i) |-> (st_q == S_IDLE));
endmodule

// File: rtl/ow_byte_ctrl.sv
module ow_byte_ctrl
  import ow_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              done_i,
  input  logic              rx_bit_i,
  input  logic              presence_i,
  output logic              start_rst_o,
  output logic              start_bit_o,
  output logic              bit_val_o,
  output logic              busy_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_presence_o
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  typedef enum logic [1:0] {C_IDLE, C_RST, C_BITS} ctl_st_e;
  ctl_st_e st_q;
  logic [DATA_W-1:0] sh_q, rx_q;
  logic [CW-1:0]     left_q;
  logic              byte_q;

  assign bit_val_o = sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= C_IDLE; sh_q <= '0; rx_q <= '0; left_q <= '0; byte_q <= 1'b0;
      start_rst_o <= 1'b0; start_bit_o <= 1'b0; busy_o <= 1'b0;
      rsp_valid_o <= 1'b0; rsp_data_o <= '0; rsp_presence_o <= 1'b0;
    end else begin
      start_rst_o <= 1'b0;
      start_bit_o <= 1'b0;
      rsp_valid_o <= 1'b0;
      case (st_q)
        C_IDLE: if (cmd_valid_i) begin
          busy_o <= 1'b1;
          byte_q <= 1'b0;
          left_q <= '0;
          rx_q   <= '0;
          case (op_e'(cmd_op_i))
            OP_RESET: begin
              start_rst_o <= 1'b1;
              st_q        <= C_RST;
            end
            OP_WR_BYTE, OP_RD_BYTE: begin
              sh_q        <= (op_e'(cmd_op_i) == OP_WR_BYTE) ? cmd_data_i : '1;
              byte_q      <= 1'b1;
              left_q      <= CW'(DATA_W - 1);
              start_bit_o <= 1'b1;
              st_q        <= C_BITS;
            end
            OP_WR0: begin
              sh_q        <= '0;
              start_bit_o <= 1'b1;
              st_q        <= C_BITS;
            end
            default: begin
              sh_q        <= '1;
              start_bit_o <= 1'b1;
              st_q        <= C_BITS;
            end
          endcase
        end
        C_RST: if (done_i) begin
          rsp_valid_o    <= 1'b1;
          rsp_presence_o <= presence_i;
          rsp_data_o     <= '0;
          busy_o         <= 1'b0;
          st_q           <= C_IDLE;
        end
        C_BITS: if (done_i) begin
          if (left_q == '0) begin
            rsp_valid_o    <= 1'b1;
            rsp_presence_o <= 1'b0;
            rsp_data_o     <= byte_q ? {rx_bit_i, rx_q[DATA_W-1:1]} : DATA_W'(rx_bit_i);
            busy_o         <= 1'b0;
            st_q           <= C_IDLE;
          end else begin
            rx_q        <= {rx_bit_i, rx_q[DATA_W-1:1]};
            sh_q        <= sh_q >> 1;
            left_q      <= left_q - 1'b1;
            start_bit_o <= 1'b1;
          end
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

  assert_accept_sets_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/ow_master.sv
module ow_master
  import ow_pkg::*;
#(
  parameter int TICK_DIV    = 600,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_op_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_presence_o,
  output logic              busy_o,
  input  logic              bus_i,
  output logic              bus_drive_low_o
);
  logic tick, bus_s, start_rst, start_bit, bit_val, done, rx_bit, presence;

  ow_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i, .rst_ni, .clr_i(start_rst | start_bit), .tick_o(tick)
  );

  ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(bus_i), .q_o(bus_s)
  );

  ow_slot_engine u_eng (
    .clk_i, .rst_ni, .tick_i(tick), .start_rst_i(start_rst), .start_bit_i(start_bit),
    .bit_val_i(bit_val), .bus_i(bus_s), .drive_low_o(bus_drive_low_o),
    .done_o(done), .rx_bit_o(rx_bit), .presence_o(presence)
  );

  ow_byte_ctrl #(.DATA_W(DATA_W)) u_ctl (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_data_i,
    .done_i(done), .rx_bit_i(rx_bit), .presence_i(presence),
    .start_rst_o(start_rst), .start_bit_o(start_bit), .bit_val_o(bit_val),
    .busy_o, .rsp_valid_o, .rsp_data_o, .rsp_presence_o
  );

  assign cmd_ready_o = !busy_o;

  assert_drive_only_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_drive_low_o |-> busy_o);
  assert_rsp_not_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !busy_o);
endmodule

// File: tb/sim_ow_master.sv
module sim_ow_master;
  localparam int DIV = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_data = '0;
  logic       cmd_ready, rsp_valid, rsp_presence, busy, drive;
  logic [7:0] rsp_data;
  logic       dev_low = 1'b0;
  logic       bus;
  assign bus = !drive && !dev_low;

  ow_master #(.TICK_DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_data_i(cmd_data), .rsp_valid_o(rsp_valid),
    .rsp_data_o(rsp_data), .rsp_presence_o(rsp_presence), .busy_o(busy),
    .bus_i(bus), .bus_drive_low_o(drive)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, failed = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // device model
  logic prev_drv = 1'b0;
  int low_start = 0, hold_until = 0, p_start = 0, p_end = 0;
  int nslot = 0, nrise = 0, rst_rise = 0, rel_cyc = 0, idx = 0;
  int start_log[64];
  int width_log[64];
  bit pres_en = 0, rd_en = 0;
  int pres_dly = 0, pres_len = 0, rd_base = 0;
  logic [7:0] rd_byte = '0;

  always @(negedge clk) begin
    if (drive && !prev_drv) begin
      low_start = cyc;
      idx = nrise - rd_base;
      if (rd_en && idx >= 0 && idx < 8 && !rd_byte[idx]) hold_until = cyc + 30;
      nrise++;
    end
    if (!drive && prev_drv) begin
      if (cyc - low_start >= 300) begin
        rst_rise = low_start;
        rel_cyc  = cyc;
        if (pres_en) begin p_start = cyc + pres_dly; p_end = p_start + pres_len; end
      end else if (nslot < 64) begin
        start_log[nslot] = low_start;
        width_log[nslot] = cyc - low_start;
        nslot++;
      end
    end
    prev_drv = drive;
    dev_low  = (cyc < hold_until) || (cyc >= p_start && cyc < p_end);
  end

  task automatic send(input logic [2:0] op, input logic [7:0] d, output int t);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    t = cyc;
  endtask

  task automatic wait_rsp(output logic [7:0] d, output bit p, output int t);
    int n = 0;
    while (!rsp_valid && n < 20000) begin @(negedge clk); n++; end
    chk(rsp_valid, "R11 response seen", rsp_valid, 1);
    d = rsp_data; p = rsp_presence; t = cyc;
    chk(!busy, "R11 busy low with response", busy, 0);
    @(negedge clk);
    chk(!rsp_valid, "R11 one-cycle response", rsp_valid, 0);
  endtask

  task automatic do_reset(input bit en, input int dly, input int len, input bit exp_p,
                          input bit timing, input string tag);
    int ta, tr; logic [7:0] d; bit p;
    pres_en = en; pres_dly = dly; pres_len = len;
    send(3'd0, 8'h00, ta);
    wait_rsp(d, p, tr);
    chk(p == exp_p, {"R3 presence ", tag}, p, exp_p);
    if (timing) begin
      chk(rst_rise - ta >= 80 && rst_rise - ta <= 82, "R2 released 10 ticks first", rst_rise - ta, 81);
      chk(rel_cyc - rst_rise == 80 * DIV, "R2 R1 reset low 80 ticks", rel_cyc - rst_rise, 80 * DIV);
      chk(tr - rel_cyc >= 640 && tr - rel_cyc <= 642, "R4 response 80 ticks after release", tr - rel_cyc, 641);
    end
    pres_en = 0;
    repeat (20) @(negedge clk);
  endtask

  task automatic test_write_byte(input logic [7:0] v);
    int ta, tr, base; logic [7:0] d; bit p;
    base = nslot;
    send(3'd1, v, ta);
    wait_rsp(d, p, tr);
    chk(nslot - base == 8, "R8 eight slots", nslot - base, 8);
    for (int i = 0; i < 8; i++) begin
      chk(width_log[base + i] == (v[i] ? DIV : 10 * DIV), "R5 R8 LSB-first slot low width",
          width_log[base + i], v[i] ? DIV : 10 * DIV);
      if (i > 0)
        chk(start_log[base + i] - start_log[base + i - 1] >= 97 &&
            start_log[base + i] - start_log[base + i - 1] <= 99, "R5 slot spacing 12 ticks",
            start_log[base + i] - start_log[base + i - 1], 98);
    end
    chk(d == v, "R7 R8 written byte echoed", d, v);
    repeat (20) @(negedge clk);
  endtask

  task automatic test_read_byte(input logic [7:0] v);
    int ta, tr, base; logic [7:0] d; bit p;
    base = nslot; rd_base = nrise; rd_byte = v; rd_en = 1;
    send(3'd2, 8'h00, ta);
    wait_rsp(d, p, tr);
    rd_en = 0;
    chk(nslot - base == 8, "R9 eight slots", nslot - base, 8);
    for (int i = 0; i < 8; i++)
      chk(width_log[base + i] == DIV, "R9 R1 read uses one-slots", width_log[base + i], DIV);
    chk(d == v, "R9 R6 byte read", d, v);
    repeat (20) @(negedge clk);
  endtask

  task automatic test_bit(input logic [2:0] op, input bit dev_zero, input int exp_w,
                          input logic [7:0] exp_d, input string tag);
    int ta, tr, base; logic [7:0] d; bit p;
    base = nslot; rd_base = nrise; rd_byte = dev_zero ? 8'h00 : 8'hFF; rd_en = 1;
    send(op, 8'h00, ta);
    wait_rsp(d, p, tr);
    rd_en = 0;
    chk(nslot - base == 1, {"R10 single slot ", tag}, nslot - base, 1);
    chk(width_log[base] == exp_w, {"R5 R10 slot width ", tag}, width_log[base], exp_w);
    chk(start_log[base] - ta >= 17 && start_log[base] - ta <= 19, {"R5 recovery 2 ticks ", tag},
        start_log[base] - ta, 18);
    chk(d == exp_d, {"R10 R6 R7 bit result ", tag}, d, exp_d);
    repeat (20) @(negedge clk);
  endtask

  task automatic test_ignore_busy();
    int ta, tr, base, r0; logic [7:0] d; bit p;
    base = nslot; r0 = nrise;
    send(3'd1, 8'h0F, ta);
    @(negedge clk);
    chk(!cmd_ready && busy, "R11 busy while running", cmd_ready, 0);
    cmd_valid = 1'b1; cmd_op = 3'd0;
    repeat (200) @(negedge clk);
    cmd_valid = 1'b0;
    wait_rsp(d, p, tr);
    chk(d == 8'h0F, "R11 byte unaffected by ignored command", d, 8'h0F);
    repeat (300) @(negedge clk);
    chk(nrise - r0 == 8, "R11 no extra bus activity", nrise - r0, 8);
    chk(nslot - base == 8, "R11 no reset run", nslot - base, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!drive && !busy && cmd_ready && !rsp_valid, "R11 reset state", {drive, busy, cmd_ready, rsp_valid}, 2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!drive && !busy && cmd_ready, "R11 idle after reset", {drive, busy, cmd_ready}, 1);

    do_reset(1, 20, 200, 1, 1, "device answers");
    do_reset(0, 0, 0, 0, 1, "no device");
    do_reset(1, 0, 20, 0, 0, "pulse before first sample");
    do_reset(1, 525, 20, 1, 0, "pulse at last sample");

    test_write_byte(8'hA5);
    test_write_byte(8'h3C);
    test_read_byte(8'h3C);
    test_read_byte(8'hFF);
    test_bit(3'd3, 0, 10 * DIV, 8'h00, "write0");
    test_bit(3'd4, 0, DIV, 8'h01, "write1");
    test_bit(3'd5, 1, DIV, 8'h00, "read zero");
    test_bit(3'd5, 0, DIV, 8'h01, "read one");
    test_bit(3'd7, 1, DIV, 8'h00, "code7");
    test_ignore_busy();

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL R11 watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule